// File: doc/BRIEF.md
# Fault-Tolerant Dimension-Ordered Route Decision Unit

This block picks the output direction for one packet at one switch of a square two-dimensional mesh. Each request carries the switch's own coordinates and the packet's destination coordinates. It also carries a blocked flag for each neighbour and a mask that shows which neighbour ports exist at this switch's place in the mesh. A corner switch has two neighbour ports, an edge switch three and an interior switch four. The unit returns one of North, South, East, West or Local as a one-hot vector with a valid flag. The result is registered one clock after the request strobe.

Routing moves along X first and then along Y. If the X move the packet needs is marked blocked, the unit drops strict X-then-Y order and moves the packet along Y instead. If no Y move is left, the packet is held: no direction is granted, so it stays in its input register and asks again later. The unit never grants a direction whose port is missing from the mask. When the routing rule would pick a missing port, the unit grants nothing and sets a routing-error flag that stays high until reset.

Top module: `xy_route_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `valid_o` is 0, `dir_o` is 0 and `route_err_o` is 0.
- R2: Inputs are sampled on a rising clock edge where `req_i` is 1, and the decision appears on the outputs after that edge. After an edge where `req_i` is 0, `valid_o` is 0 and `dir_o` is 0.
- R3: If the current X is greater than the destination X and West (blocked/mask bit 3) is not blocked, the unit grants West (`dir_o` = 5'b01000).
- R4: If the current X is less than the destination X and East (bit 2) is not blocked, the unit grants East (`dir_o` = 5'b00100).
- R5: If the X coordinates are equal, the unit grants North (`dir_o` = 5'b00001, bit 0) when the current Y is less than the destination Y, and South (`dir_o` = 5'b00010, bit 1) when it is greater.
- R6: If the needed X direction is blocked, the unit takes the Y rule of R5 instead.
- R7: If the needed X direction is blocked and the Y coordinates are equal, `valid_o` and `dir_o` are 0 and `route_err_o` does not change.
- R8: If both coordinates are equal, the unit grants Local (`dir_o` = 5'b10000, bit 4), whatever the blocked flags and the mask are.
- R9: Blocked flags other than the one for the needed X direction have no effect. In particular, a Y move is granted even if that Y direction is flagged blocked.
- R10: A neighbour direction whose mask bit is 0 is never granted. If the routing rule picks such a direction, `valid_o` and `dir_o` are 0 and `route_err_o` becomes 1 and stays 1 until reset.
- R11: `dir_o` has at most one bit set, and `valid_o` is 1 exactly when one bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Request strobe; the other inputs are sampled when it is 1 |
| cur_x_i | input | CW | X coordinate of this switch |
| cur_y_i | input | CW | Y coordinate of this switch |
| dst_x_i | input | CW | Destination X coordinate |
| dst_y_i | input | CW | Destination Y coordinate |
| blocked_i | input | 4 | Neighbour blocked flags: bit 0 North, 1 South, 2 East, 3 West |
| port_mask_i | input | 4 | Neighbour port present, same bit order as `blocked_i` |
| dir_o | output | 5 | One-hot direction: bit 0 North, 1 South, 2 East, 3 West, 4 Local |
| valid_o | output | 1 | A direction is granted |
| route_err_o | output | 1 | Sticky flag: the rule picked a missing port |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- `dir_o` has at most one bit set and agrees with `valid_o`.
- Nothing is granted after a cycle without a request.
- A granted neighbour port was present in the sampled mask.
- The error flag stays set once it is set.
- A packet that has reached its destination is sent to Local.
- An unblocked westward move goes West.

Only the bench scenarios show the full decision. These cover the blocked-X turn into Y and the hold when no Y move is left. They also cover a blocked Y direction that is ignored, an error raised by a wrong mask, and the clearing of that error by a later reset. The bench checks each of these against a behavioural model on every clock.

// File: rtl/xy_route_pkg.sv
package xy_route_pkg;

  localparam int NBR_PORTS = 4;
  localparam int DIR_BITS  = NBR_PORTS + 1;

  localparam int IDX_N   = 0;
  localparam int IDX_S   = 1;
  localparam int IDX_E   = 2;
  localparam int IDX_W   = 3;
  localparam int IDX_LOC = 4;

  typedef struct packed {
    logic below;
    logic above;
    logic same;
  } axis_rel_t;

  typedef logic [DIR_BITS-1:0]  dir_vec_t;
  typedef logic [NBR_PORTS-1:0] nbr_vec_t;

endpackage

// File: rtl/xy_axis_cmp.sv
module xy_axis_cmp #(
  parameter int CW = 2
) (
  input  logic [CW-1:0]            here,
  input  logic [CW-1:0]            goal,
  output xy_route_pkg::axis_rel_t  rel
);
  always_comb begin
    rel.below = (here < goal);
    rel.above = (here > goal);
    rel.same  = (here == goal);
  end
endmodule

// File: rtl/xy_dir_select.sv
module xy_dir_select
  import xy_route_pkg::*;
(
  input  axis_rel_t xrel,
  input  axis_rel_t yrel,
  input  nbr_vec_t  blocked,
  output dir_vec_t  pick
);
  logic want_w, want_e, x_free, use_y;

  always_comb begin
    want_w = xrel.above;
    want_e = xrel.below;
    x_free = (want_w && !blocked[IDX_W]) || (want_e && !blocked[IDX_E]);
    use_y  = xrel.same || !x_free;
    pick   = '0;
    if (xrel.same && yrel.same) begin
      pick[IDX_LOC] = 1'b1;
    end else if (!use_y) begin
      pick[IDX_W] = want_w;
      pick[IDX_E] = want_e;
    end else begin
      pick[IDX_N] = yrel.below;
      pick[IDX_S] = yrel.above;
    end
  end
endmodule

// File: rtl/xy_port_guard.sv
module xy_port_guard
  import xy_route_pkg::*;
(
  input  dir_vec_t pick,
  input  nbr_vec_t present,
  output dir_vec_t grant,
  output logic     missing
);
  nbr_vec_t miss_vec;

  for (genvar p = 0; p < NBR_PORTS; p++) begin : g_port
    assign grant[p]    = pick[p] & present[p];
    assign miss_vec[p] = pick[p] & ~present[p];
  end
  assign grant[IDX_LOC] = pick[IDX_LOC];
  assign missing        = |miss_vec;
endmodule

// File: rtl/xy_route_unit.sv
module xy_route_unit
  import xy_route_pkg::*;
#(
  parameter int MESH_N = 4,
  parameter int CW     = (MESH_N > 1) ? $clog2(MESH_N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_i,
  input  logic [CW-1:0] cur_x_i,
  input  logic [CW-1:0] cur_y_i,
  input  logic [CW-1:0] dst_x_i,
  input  logic [CW-1:0] dst_y_i,
  input  logic [3:0]    blocked_i,
  input  logic [3:0]    port_mask_i,
  output logic [4:0]    dir_o,
  output logic          valid_o,
  output logic          route_err_o
);
  localparam int NDIM = 2;

  logic [CW-1:0] here_v [NDIM];
  logic [CW-1:0] goal_v [NDIM];
  axis_rel_t     rel_v  [NDIM];

  assign here_v[0] = cur_x_i;
  assign here_v[1] = cur_y_i;
  assign goal_v[0] = dst_x_i;
  assign goal_v[1] = dst_y_i;

  for (genvar d = 0; d < NDIM; d++) begin : g_axis
    xy_axis_cmp #(.CW(CW)) u_cmp (
      .here (here_v[d]),
      .goal (goal_v[d]),
      .rel  (rel_v[d])
    );
  end

  dir_vec_t pick, grant;
  logic     missing;

  xy_dir_select u_sel (
    .xrel    (rel_v[0]),
    .yrel    (rel_v[1]),
    .blocked (blocked_i),
    .pick    (pick)
  );

  xy_port_guard u_guard (
    .pick    (pick),
    .present (port_mask_i),
    .grant   (grant),
    .missing (missing)
  );

  dir_vec_t dir_q;
  logic     valid_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (req_i) begin
      dir_q   <= grant;
      valid_q <= |grant;
      if (missing) err_q <= 1'b1;
    end else begin
      dir_q   <= '0;
      valid_q <= 1'b0;
    end
  end

  assign dir_o       = dir_q;
  assign valid_o     = valid_q;
  assign route_err_o = err_q;
endmodule

// File: rtl/xy_route_unit_chk.sv
module xy_route_unit_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_i,
  input logic [CW-1:0] cur_x_i,
  input logic [CW-1:0] cur_y_i,
  input logic [CW-1:0] dst_x_i,
  input logic [CW-1:0] dst_y_i,
  input logic [3:0]    blocked_i,
  input logic [3:0]    port_mask_i,
  input logic [4:0]    dir_o,
  input logic          valid_o,
  input logic          route_err_o
);
  AST_DIR_ONEHOT0: assert property (@(posedge clk) disable iff (rst) $onehot0(dir_o)); // R11
  AST_VALID_AGREES: assert property (@(posedge clk) disable iff (rst) valid_o == ($countones(dir_o) == 1)); // R11
  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst) !$past(req_i) |-> !valid_o); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) route_err_o |=> route_err_o); // R10
  AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !dir_o[4]) |-> ((dir_o[3:0] & $past(port_mask_i)) != 4'b0)); // R10
  AST_LOCAL_AT_HOME: assert property (@(posedge clk) disable iff (rst)
    ($past(req_i) && $past(cur_x_i) == $past(dst_x_i) && $past(cur_y_i) == $past(dst_y_i))
    |-> (valid_o && dir_o[4])); // R8
  AST_WEST_FREE: assert property (@(posedge clk) disable iff (rst)
    ($past(req_i) && $past(cur_x_i) > $past(dst_x_i) && !$past(blocked_i[3]) && $past(port_mask_i[3]))
    |-> dir_o[3]); // R3
endmodule

bind xy_route_unit xy_route_unit_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i),
  .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
  .blocked_i(blocked_i), .port_mask_i(port_mask_i),
  .dir_o(dir_o), .valid_o(valid_o), .route_err_o(route_err_o)
);

// File: tb/xy_route_unit_tb.sv
module xy_route_unit_tb;
  localparam int N  = 4;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [CW-1:0] cx = '0, cy = '0, dx = '0, dy = '0;
  logic [3:0] blk = '0, msk = '0;
  logic [4:0] dir;
  logic valid, err;

  int n_checks = 0;
  int n_fail   = 0;

  int    exp_dir = 0;
  bit    exp_valid = 0, exp_err = 0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  xy_route_unit #(.MESH_N(N), .CW(CW)) u_dut (
    .clk(clk), .rst(rst), .req_i(req),
    .cur_x_i(cx), .cur_y_i(cy), .dst_x_i(dx), .dst_y_i(dy),
    .blocked_i(blk), .port_mask_i(msk),
    .dir_o(dir), .valid_o(valid), .route_err_o(err)
  );

  function automatic logic [3:0] pos_mask(int x, int y);
    logic [3:0] m;
    m[0] = (y < N-1);
    m[1] = (y > 0);
    m[2] = (x < N-1);
    m[3] = (x > 0);
    return m;
  endfunction

  // behavioural reference: bit 0 N, 1 S, 2 E, 3 W, 4 Local
  always @(posedge clk) begin
    if (rst) begin
      exp_dir = 0; exp_valid = 0; exp_err = 0; exp_tag = "R1";
    end else if (!req) begin
      exp_dir = 0; exp_valid = 0; exp_tag = "R2";
    end else begin
      int ix, iy, jx, jy, want;
      bit fallback;
      ix = int'(cx); iy = int'(cy); jx = int'(dx); jy = int'(dy);
      want = -1; fallback = 0;
      if (ix == jx && iy == jy) want = 4;
      else if (ix > jx && !blk[3]) want = 3;
      else if (ix < jx && !blk[2]) want = 2;
      else begin
        fallback = (ix != jx);
        if (iy < jy) want = 0;
        else if (iy > jy) want = 1;
      end
      if (want == 4) exp_tag = "R8";
      else if (want < 0) exp_tag = "R7";
      else if (fallback) exp_tag = "R6";
      else if (blk != 4'b0) exp_tag = "R9";
      else if (want == 3) exp_tag = "R3";
      else if (want == 2) exp_tag = "R4";
      else exp_tag = "R5";
      if (want >= 0 && want < 4 && !msk[want]) begin
        exp_err = 1; want = -1; exp_tag = "R10";
      end
      exp_valid = (want >= 0);
      exp_dir   = (want >= 0) ? (1 << want) : 0;
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (int'(dir) != exp_dir || valid !== exp_valid || err !== exp_err) begin
      n_fail++;
      $display("FAIL %s: dir=%b valid=%b err=%b expected dir=%b valid=%b err=%b",
               exp_tag, dir, valid, err, exp_dir[4:0], exp_valid, exp_err);
    end
    n_checks++;
    if ($countones(dir) > 1 || valid !== (dir != 5'b0)) begin
      n_fail++;
      $display("FAIL R11: dir=%b valid=%b expected at most one bit agreeing with valid", dir, valid);
    end
  end

  task automatic step(bit r, int x, int y, int tx, int ty, logic [3:0] b, logic [3:0] m);
    @(posedge clk); #2;
    req = r; cx = CW'(x); cy = CW'(y); dx = CW'(tx); dy = CW'(ty); blk = b; msk = m;
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst = 1'b1; req = 1'b0;
    repeat (3) @(posedge clk);
    #2; rst = 1'b0;
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);      // R1 reset state checked each cycle
    #2; rst = 1'b0;
    step(1, 1, 1, 1, 1, 4'hF, 4'hF);           // R8 local despite all blocked
    step(1, 2, 1, 0, 3, 4'h0, pos_mask(2,1));  // R3 west
    step(1, 1, 2, 3, 0, 4'h0, pos_mask(1,2));  // R4 east
    step(1, 2, 0, 2, 3, 4'h0, pos_mask(2,0));  // R5 north
    step(1, 2, 3, 2, 0, 4'h0, pos_mask(2,3));  // R5 south
    step(1, 2, 1, 0, 3, 4'b1000, pos_mask(2,1)); // R6 west blocked -> north
    step(1, 1, 2, 3, 0, 4'b0100, pos_mask(1,2)); // R6 east blocked -> south
    step(1, 2, 1, 0, 1, 4'b1000, pos_mask(2,1)); // R7 hold
    step(1, 1, 1, 3, 1, 4'b1011, pos_mask(1,1)); // R9 east despite others
    step(1, 2, 0, 2, 3, 4'b0001, pos_mask(2,0)); // R9 north despite its flag
    step(0, 2, 0, 2, 3, 4'h0, pos_mask(2,0));    // R2 no request
    step(1, 3, 3, 0, 0, 4'h0, pos_mask(3,3));    // corner, west
    step(1, 0, 0, 0, 2, 4'h0, 4'b1110);          // R10 north missing -> error
    step(1, 1, 1, 1, 1, 4'h0, 4'hF);             // R10 error stays set
    step(0, 0, 0, 0, 0, 4'h0, 4'h0);
    do_reset();                                  // R1 error cleared
    for (int i = 0; i < 400; i++) begin
      int x, y;
      x = $urandom_range(0, N-1); y = $urandom_range(0, N-1);
      step($urandom_range(0, 3) != 0, x, y, $urandom_range(0, N-1), $urandom_range(0, N-1),
           4'($urandom_range(0, 15)), pos_mask(x, y));
    end
    for (int i = 0; i < 200; i++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, N-1), $urandom_range(0, N-1),
           $urandom_range(0, N-1), $urandom_range(0, N-1),
           4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
    end
    step(0, 0, 0, 0, 0, 4'h0, 4'h0);
    repeat (2) @(posedge clk);
    #3;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule